// File: doc/BRIEF.md
# Self-Shifting Bubble FIFO

This block is an elastic first-in first-out buffer built as a chain of 16 slots, each holding a 4-bit word and one occupancy marker. A word written at the input end moves one slot toward the output end on every clock, as long as the slot ahead of it is empty. A freed slot therefore moves back toward the input end one position per clock. No read or write pointers exist. Occupancy is simply the set of marker bits spread along the chain.

A producer watches the input-ready flag and pulses the shift-in strobe together with a word. A consumer watches the output-ready flag, reads the word at the output, and pulses the shift-out strobe to remove it. The whole chain runs on one clock and moves each word at most one slot per clock. A synchronous active-high reset empties the buffer.

Top module: `bubble_fifo`

## Requirements
- R1: With reset high at a clock edge, every marker clears. After that edge in_ready is 1 and out_ready is 0.
- R2: A shift_in pulse while in_ready is 1 stores data_in in the input slot, and in_ready reads 0 after that edge.
- R3: A shift_in pulse while in_ready is 0 is ignored. The word never appears at the output, and the occupancy does not change.
- R4: A shift_out pulse while out_ready is 1 removes the word at the output slot, and out_ready reads 0 after that edge.
- R5: A shift_out pulse while out_ready is 0 is ignored and removes nothing.
- R6: A word accepted into an empty buffer at some edge makes out_ready rise after exactly the 15th later edge, and data_out then shows that word.
- R7: Words leave in the order they were accepted.
- R8: The buffer holds 16 words. After 16 accepted writes with no removal, in_ready stays 0 and all 16 words can be read out.
- R9: A full slot that is not handing its word on keeps its marker set and its word unchanged.
- R10: When a word is removed from a full buffer, the next word reaches the output slot on the following edge. out_ready is low for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, empties the chain |
| shift_in | input | 1 | Write strobe, taken only while in_ready is 1 |
| data_in | input | 4 | Word to write |
| in_ready | output | 1 | 1 when the input slot is empty |
| shift_out | input | 1 | Remove strobe, taken only while out_ready is 1 |
| data_out | output | 4 | Word held in the output slot |
| out_ready | output | 1 | 1 when the output slot holds a word |

## Verification
The hardest state to reach from the ports is a completely full chain with a freed slot moving back toward the input while the output end is drained. Words take 15 cycles to settle and a new write can only follow every other cycle. The bench therefore writes whenever in_ready is seen high, idles long enough for the whole chain to pack, and then starts removing words. It also pulses both strobes while their flags are low and shows through the output order that nothing was written or lost.

// File: rtl/bubble_fifo_pkg.sv
package bubble_fifo_pkg;

    localparam int DEF_DEPTH = 16;
    localparam int DEF_WIDTH = 4;

    // What a slot does on the coming edge
    typedef enum logic [1:0] {
        SLOT_HOLD  = 2'd0,
        SLOT_LOAD  = 2'd1,
        SLOT_DRAIN = 2'd2
    } slot_op_e;

    // An empty slot pulls a word from a full neighbour upstream
    function automatic logic slot_advances(input logic self_full, input logic prev_full);
        return prev_full && !self_full;
    endfunction

endpackage

// File: rtl/bubble_slot.sv
module bubble_slot
    import bubble_fifo_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_full,
    input  logic [WIDTH-1:0] up_word,
    input  logic             down_take,
    output logic             full,
    output logic [WIDTH-1:0] word
);

    slot_op_e op;

    always_comb begin
        if (slot_advances(full, up_full)) begin
            op = SLOT_LOAD;
        end else if (down_take) begin
            op = SLOT_DRAIN;
        end else begin
            op = SLOT_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            word <= '0;
        end else begin
            case (op)
                SLOT_LOAD: begin
                    full <= 1'b1;
                    word <= up_word;
                end
                SLOT_DRAIN: full <= 1'b0;
                default: ;
            endcase
        end
    end

    // R9: a held word stays put
    p_hold_word_r9: assert property (@(posedge clk) disable iff (rst)
        (full && !down_take) |=> (full && $stable(word)));

    // R9: the downstream side only takes from an occupied slot
    p_take_valid_r9: assert property (@(posedge clk) disable iff (rst)
        down_take |-> full);

endmodule

// File: rtl/bubble_chain.sv
module bubble_chain
    import bubble_fifo_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_word,
    input  logic             pop,
    output logic [DEPTH-1:0] full_vec,
    output logic [WIDTH-1:0] head_word
);

    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0] take;
    logic [WIDTH-1:0] word_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic             up_f;
        logic [WIDTH-1:0] up_w;

        if (i == 0) begin : g_in
            assign up_f = push;
            assign up_w = push_word;
        end else begin : g_mid
            assign up_f = full_vec[i-1];
            assign up_w = word_q[i-1];
        end

        if (i == LAST) begin : g_out
            assign take[i] = pop && full_vec[i];
        end else begin : g_fwd
            assign take[i] = full_vec[i] && !full_vec[i+1];
        end

        bubble_slot #(.WIDTH(WIDTH)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .up_full   (up_f),
            .up_word   (up_w),
            .down_take (take[i]),
            .full      (full_vec[i]),
            .word      (word_q[i])
        );
    end

    assign head_word = word_q[LAST];

endmodule

// File: rtl/bubble_fifo.sv
module bubble_fifo
    import bubble_fifo_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] data_in,
    output logic             in_ready,
    input  logic             shift_out,
    output logic [WIDTH-1:0] data_out,
    output logic             out_ready
);

    logic [DEPTH-1:0] full_vec;
    logic             accept;
    logic             remove;
    int               occ;

    bubble_chain #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .push      (shift_in),
        .push_word (data_in),
        .pop       (shift_out),
        .full_vec  (full_vec),
        .head_word (data_out)
    );

    assign in_ready  = !full_vec[0];
    assign out_ready = full_vec[DEPTH-1];
    assign accept    = shift_in && in_ready;
    assign remove    = shift_out && out_ready;

    always_comb occ = $countones(full_vec);

    // R1: reset empties the chain
    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> (occ == 0));

    // R2: an accepted write occupies the input slot
    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_ready);

    // R4: a removal frees the output slot
    p_remove_r4: assert property (@(posedge clk) disable iff (rst)
        remove |=> !out_ready);

    // R3 and R5: occupancy moves only by accepted writes and removals
    p_occupancy_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (occ == $past(occ) + int'($past(accept)) - int'($past(remove))));

endmodule

// File: tb/sim_bubble_fifo.sv
`timescale 1ns/1ps
module sim_bubble_fifo;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       shift_in = 1'b0;
    logic       shift_out = 1'b0;
    logic [3:0] data_in = 4'h0;
    logic       in_ready;
    logic       out_ready;
    logic [3:0] data_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bubble_fifo u0 (
        .clk       (clk),
        .rst       (rst),
        .shift_in  (shift_in),
        .data_in   (data_in),
        .in_ready  (in_ready),
        .shift_out (shift_out),
        .data_out  (data_out),
        .out_ready (out_ready)
    );

    typedef struct packed {
        logic       si;
        logic       so;
        logic [3:0] din;
        logic       ein;
        logic       eout;
    } vec_t;

    // R2/R3/R5 opening sequence on an empty buffer, expected flags after each edge
    localparam vec_t VECS [5] = '{
        '{si: 1'b1, so: 1'b0, din: 4'hA, ein: 1'b0, eout: 1'b0},
        '{si: 1'b1, so: 1'b0, din: 4'hB, ein: 1'b1, eout: 1'b0},
        '{si: 1'b1, so: 1'b0, din: 4'hC, ein: 1'b0, eout: 1'b0},
        '{si: 1'b0, so: 1'b0, din: 4'h0, ein: 1'b1, eout: 1'b0},
        '{si: 1'b0, so: 1'b1, din: 4'h0, ein: 1'b1, eout: 1'b0}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic si, input logic so, input logic [3:0] d);
        @(negedge clk);
        shift_in  = si;
        shift_out = so;
        data_in   = d;
        @(posedge clk);
        #2;
        shift_in  = 1'b0;
        shift_out = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, actual running expected finished");
        finish_run();
    end

    initial begin
        int guard;
        int n;
        do_reset();
        check("R1 in_ready after reset", {7'd0, in_ready}, 8'd1);
        check("R1 out_ready after reset", {7'd0, out_ready}, 8'd0);

        // table walk: A accepted, B dropped, C accepted, pop on empty dropped
        for (int v = 0; v < 5; v++) begin
            step(VECS[v].si, VECS[v].so, VECS[v].din);
            check($sformatf("R2/R3/R5 vec %0d in_ready", v), {7'd0, in_ready}, {7'd0, VECS[v].ein});
            check($sformatf("R2/R3/R5 vec %0d out_ready", v), {7'd0, out_ready}, {7'd0, VECS[v].eout});
        end

        // R6: A accepted at step 0, table used steps 1..4
        for (int k = 5; k < 15; k++) begin
            step(1'b0, 1'b0, 4'h0);
            if (k == 14) check("R6 out_ready before 15th edge", {7'd0, out_ready}, 8'd0);
        end
        step(1'b0, 1'b0, 4'h0);
        check("R6 out_ready at 15th edge", {7'd0, out_ready}, 8'd1);
        check("R6 data_out first word", {4'd0, data_out}, 8'h0A);

        step(1'b0, 1'b1, 4'h0);
        check("R4 out_ready after removal", {7'd0, out_ready}, 8'd0);
        step(1'b0, 1'b0, 4'h0);
        check("R7 second word present", {7'd0, out_ready}, 8'd1);
        check("R3 dropped word absent, next is C", {4'd0, data_out}, 8'h0C);
        step(1'b0, 1'b1, 4'h0);
        for (int k = 0; k < 20; k++) step(1'b0, 1'b0, 4'h0);
        check("R3 nothing left behind", {7'd0, out_ready}, 8'd0);
        check("R3 input slot free", {7'd0, in_ready}, 8'd1);

        // R8: fill with 16 words
        n = 0;
        guard = 0;
        while (n < 16 && guard < 400) begin
            if (in_ready) begin
                step(1'b1, 1'b0, n[3:0]);
                n++;
            end else begin
                step(1'b0, 1'b0, 4'h0);
            end
            guard++;
        end
        check("R8 sixteen writes accepted", n[7:0], 8'd16);
        for (int k = 0; k < 40; k++) step(1'b0, 1'b0, 4'h0);
        check("R8 in_ready low when full", {7'd0, in_ready}, 8'd0);
        check("R8 out_ready high when full", {7'd0, out_ready}, 8'd1);
        step(1'b1, 1'b0, 4'hF);
        check("R3 write while full leaves in_ready low", {7'd0, in_ready}, 8'd0);

        // R7/R10: drain in order
        for (int w = 0; w < 16; w++) begin
            guard = 0;
            while (!out_ready && guard < 40) begin
                step(1'b0, 1'b0, 4'h0);
                guard++;
            end
            check($sformatf("R7 word %0d order", w), {4'd0, data_out}, w[7:0]);
            step(1'b0, 1'b1, 4'h0);
            if (w == 0) begin
                check("R10 out_ready low one cycle", {7'd0, out_ready}, 8'd0);
                step(1'b0, 1'b0, 4'h0);
                check("R10 next word arrives next edge", {7'd0, out_ready}, 8'd1);
                check("R10 next word value", {4'd0, data_out}, 8'h01);
            end
        end
        for (int k = 0; k < 40; k++) step(1'b0, 1'b0, 4'h0);
        check("R3 word written while full never appears", {7'd0, out_ready}, 8'd0);
        step(1'b0, 1'b1, 4'h0);
        check("R5 removal on empty keeps out_ready low", {7'd0, out_ready}, 8'd0);

        // R5: a removal on empty must not swallow a later word
        step(1'b1, 1'b0, 4'h5);
        for (int k = 0; k < 15; k++) step(1'b0, 1'b0, 4'h0);
        check("R5 later word still arrives", {7'd0, out_ready}, 8'd1);
        check("R5 later word value", {4'd0, data_out}, 8'h05);

        // R1: reset in the middle of traffic
        step(1'b1, 1'b0, 4'h7);
        step(1'b0, 1'b0, 4'h0);
        step(1'b1, 1'b0, 4'h8);
        do_reset();
        check("R1 in_ready after mid reset", {7'd0, in_ready}, 8'd1);
        check("R1 out_ready after mid reset", {7'd0, out_ready}, 8'd0);
        for (int k = 0; k < 20; k++) step(1'b0, 1'b0, 4'h0);
        check("R1 no word survives reset", {7'd0, out_ready}, 8'd0);

        finish_run();
    end

endmodule